// File: doc/BRIEF.md
# FIFO Interrupt Status Controller

This block holds the interrupt register set of a FIFO-based serial controller. It merges three sticky event flags (transmit underflow, receive overflow, mode fault) with four live level flags derived from FIFO occupancy, full indications and two programmable thresholds. Software clears sticky flags by writing ones to the status register. The mask is changed only through a pair of set-enable and clear-enable registers, and software can read it back from a separate read-only register.

A single level interrupt output is high while any status bit is also enabled in the mask. The block has a simple register bus with a one-cycle write strobe and combinational read data. It takes FIFO counts, full flags and single-cycle event pulses from the surrounding controller. Serial transfer logic lives elsewhere.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed: 6 TX underflow, 5 RX full, 4 RX at-threshold, 3 TX full, 2 TX below-threshold, 1 mode fault, 0 RX overflow. Bits above 6 read as zero.
- R2: Bits 6, 1 and 0 are sticky. An event pulse sets its bit on the next clock edge. The bit stays set until a write to the status register (word offset 0x04) has a 1 in that position.
- R3: Bit 4 reads 1 whenever the RX count is greater than or equal to the RX threshold. Bit 2 reads 1 whenever the TX count is less than the TX threshold. Both are combinational.
- R4: Bit 5 equals the RX-full input and bit 3 equals the TX-full input, combinationally.
- R5: A write to offset 0x08 sets every mask bit that has a 1 in the write data. A write to offset 0x0C clears every mask bit that has a 1 in the write data. Both take effect on the next edge.
- R6: The mask reads at offset 0x10. Writes to 0x10 leave it unchanged. Reads of 0x08 and 0x0C return zero.
- R7: The interrupt output is high exactly when (mask & status) is nonzero.
- R8: After reset the mask and all sticky bits are zero and the interrupt output is low.
- R9: If an event pulse and a clearing write to the same bit fall in one cycle, the bit ends up set.
- R10: Writes to the status register have no effect on the level bits 5, 4, 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tx_count | input | 6 | TX FIFO occupancy |
| rx_count | input | 6 | RX FIFO occupancy |
| tx_full | input | 1 | TX FIFO full flag |
| rx_full | input | 1 | RX FIFO full flag |
| tx_thresh | input | 6 | TX below-threshold level |
| rx_thresh | input | 6 | RX at-threshold level |
| ev_tx_underflow | input | 1 | TX underflow event pulse |
| ev_rx_overflow | input | 1 | RX overflow event pulse |
| ev_mode_fault | input | 1 | Mode fault event pulse |
| irq | output | 1 | Level interrupt |

## Verification
Level bits and the interrupt output follow the FIFO inputs in the same cycle, so the bench checks them after a short settle, with no clock edge in between. Sticky bits, mask updates and clearing writes are registered, so their effect is due one edge after the stimulus. The bench drives inputs at the falling edge and samples after the next rising edge. The same-cycle case drives a pulse and a clearing write together and reads the status one edge later.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
   localparam int NUM_SRC = 7;
   localparam int B_RX_OVF  = 0;
   localparam int B_MFAULT  = 1;
   localparam int B_TX_LOW  = 2;
   localparam int B_TX_FULL = 3;
   localparam int B_RX_THR  = 4;
   localparam int B_RX_FULL = 5;
   localparam int B_TX_UNF  = 6;
   localparam logic [NUM_SRC-1:0] STICKY_MASK = 7'b100_0011;
   localparam logic [7:0] OFF_STATUS = 8'h04;
   localparam logic [7:0] OFF_SET_EN = 8'h08;
   localparam logic [7:0] OFF_CLR_EN = 8'h0C;
   localparam logic [7:0] OFF_MASK   = 8'h10;
endpackage

// File: rtl/irq_level_src.sv
module irq_level_src
   import fifo_irq_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_thresh,
   input  logic [CNT_W-1:0] rx_thresh,
   input  logic             tx_full,
   input  logic             rx_full,
   output logic [NUM_SRC-1:0] level_bits
);
   always_comb begin
      level_bits            = '0;
      level_bits[B_RX_FULL] = rx_full;
      level_bits[B_RX_THR]  = (rx_count >= rx_thresh);
      level_bits[B_TX_FULL] = tx_full;
      level_bits[B_TX_LOW]  = (tx_count < tx_thresh);
   end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
   import fifo_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_vec,
   input  logic [NUM_SRC-1:0] clr_vec,
   output logic [NUM_SRC-1:0] sticky_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          sticky_q[i] <= 1'b0;
            else if (set_vec[i]) sticky_q[i] <= 1'b1;
            else if (clr_vec[i]) sticky_q[i] <= 1'b0;
         end
         // R9: a pulse beats a same-cycle clear
         p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> sticky_q[i]);
         // R2: a bit falls only when a clear was written
         p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_q[i] && !set_vec[i] && !clr_vec[i]) |=> sticky_q[i]);
      end else begin : g_none
         assign sticky_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import fifo_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (set_we) mask_q <= mask_q | wbits;
      else if (clr_we) mask_q <= mask_q & ~wbits;
   end
   // R5: an enable write leaves the written bits set
   p_enable_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
   // R6: without an enable or disable write the mask holds
   p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
   import fifo_irq_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic              tx_full,
   input  logic              rx_full,
   input  logic [CNT_W-1:0]  tx_thresh,
   input  logic [CNT_W-1:0]  rx_thresh,
   input  logic              ev_tx_underflow,
   input  logic              ev_rx_overflow,
   input  logic              ev_mode_fault,
   output logic              irq
);
   initial begin
      if (DATA_W < NUM_SRC) $error("DATA_W too narrow for status bits");
      if (ADDR_W < 8)       $error("ADDR_W must hold offset 0x10");
      if (CNT_W < 1)        $error("CNT_W must be positive");
   end

   logic [NUM_SRC-1:0] level_bits, sticky_q, mask_q, status, ev_vec, clr_vec;
   logic [NUM_SRC-1:0] wbits;
   logic               wr_status, wr_set, wr_clr;

   assign wbits     = reg_wdata[NUM_SRC-1:0];
   assign wr_status = reg_wr && (reg_addr == ADDR_W'(OFF_STATUS));
   assign wr_set    = reg_wr && (reg_addr == ADDR_W'(OFF_SET_EN));
   assign wr_clr    = reg_wr && (reg_addr == ADDR_W'(OFF_CLR_EN));

   always_comb begin
      ev_vec           = '0;
      ev_vec[B_TX_UNF] = ev_tx_underflow;
      ev_vec[B_MFAULT] = ev_mode_fault;
      ev_vec[B_RX_OVF] = ev_rx_overflow;
   end
   assign clr_vec = wr_status ? (wbits & STICKY_MASK) : '0;

   irq_level_src #(.CNT_W(CNT_W)) u_level (
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .tx_full(tx_full), .rx_full(rx_full),
      .level_bits(level_bits));

   irq_sticky_bank u_sticky (
      .clk(clk), .rst_n(rst_n),
      .set_vec(ev_vec), .clr_vec(clr_vec), .sticky_q(sticky_q));

   irq_mask_reg u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_set), .clr_we(wr_clr), .wbits(wbits), .mask_q(mask_q));

   assign status = (sticky_q & STICKY_MASK) | (level_bits & ~STICKY_MASK);
   assign irq    = |(status & mask_q);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFF_STATUS))    reg_rdata[NUM_SRC-1:0] = status;
      else if (reg_addr == ADDR_W'(OFF_MASK)) reg_rdata[NUM_SRC-1:0] = mask_q;
   end

   // R8: nothing pending straight after reset
   p_reset_quiet_r8: assert property (@(posedge clk)
      $rose(rst_n) |-> (mask_q == '0 && !irq));
   // R7: the interrupt follows mask and status
   p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((mask_q & status) != '0));
   // R4: full flags appear unchanged in status
   p_full_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_RX_FULL] == rx_full && status[B_TX_FULL] == tx_full);
endmodule

// File: tb/fifo_irq_ctrl_test.sv
module fifo_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   logic clk = 0, rst_n = 0, reg_wr = 0;
   logic [7:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic [5:0] tx_count = 0, rx_count = 0, tx_thresh = 1, rx_thresh = 1;
   logic tx_full = 0, rx_full = 0, ev_u = 0, ev_o = 0, ev_m = 0, irq;
   int n_chk = 0, n_ok = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_irq_ctrl uut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .tx_count, .rx_count, .tx_full, .rx_full, .tx_thresh, .rx_thresh,
      .ev_tx_underflow(ev_u), .ev_rx_overflow(ev_o), .ev_mode_fault(ev_m), .irq);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act === exp) n_ok++;
      else $display("FAIL %s actual=%h expected=%h", req, act, exp);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0; reg_wdata = 0;
   endtask

   task automatic pulse(input logic u, input logic o, input logic m);
      @(negedge clk); ev_u = u; ev_o = o; ev_m = m;
      @(negedge clk); ev_u = 0; ev_o = 0; ev_m = 0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h10, d); check("R8 mask", d, 0);
      check("R8 irq", {31'b0, irq}, 0);
      rd(8'h04, d); check("R8 status", d, 32'h04);
   endtask

   task automatic t_levels();
      logic [31:0] d;
      @(negedge clk); rx_count = 5; rx_thresh = 5; tx_count = 3; tx_thresh = 3;
      rd(8'h04, d); check("R3 rx at thr, tx not below", d, 32'h10);
      @(negedge clk); rx_count = 4; tx_count = 2;
      rd(8'h04, d); check("R3 rx below, tx below", d, 32'h04);
      @(negedge clk); rx_full = 1; tx_full = 1;
      rd(8'h04, d); check("R4 R1 full flags", d, 32'h2C);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, d); check("R10 level bits kept", d, 32'h2C);
      @(negedge clk); rx_full = 0; tx_full = 0; tx_count = 0; rx_count = 0;
      tx_thresh = 1; rx_thresh = 1;
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      pulse(1, 1, 1);
      rd(8'h04, d); check("R2 sticky set", d, 32'h47);
      wr(8'h04, 32'h01);
      rd(8'h04, d); check("R2 clear bit0", d, 32'h46);
      wr(8'h04, 32'h42);
      rd(8'h04, d); check("R2 clear rest", d, 32'h04);
   endtask

   task automatic t_race();
      logic [31:0] d;
      @(negedge clk); ev_m = 1; reg_wr = 1; reg_addr = 8'h04; reg_wdata = 32'h02;
      @(negedge clk); ev_m = 0; reg_wr = 0; reg_wdata = 0;
      rd(8'h04, d); check("R9 pulse wins", d, 32'h06);
      wr(8'h04, 32'h02);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(8'h08, 32'h41);
      rd(8'h10, d); check("R5 enable", d, 32'h41);
      wr(8'h08, 32'h02);
      wr(8'h0C, 32'h01);
      rd(8'h10, d); check("R5 disable", d, 32'h42);
      wr(8'h10, 32'h7F);
      rd(8'h10, d); check("R6 mask read-only", d, 32'h42);
      rd(8'h08, d); check("R6 enable reads zero", d, 0);
      rd(8'h0C, d); check("R6 disable reads zero", d, 0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      rd(8'h04, d);
      check("R7 irq low, masked bits clear", {31'b0, irq}, 0);
      pulse(1, 0, 0);
      #1 check("R7 irq on underflow", {31'b0, irq}, 1);
      wr(8'h04, 32'h40);
      #1 check("R7 irq off after clear", {31'b0, irq}, 0);
      wr(8'h08, 32'h04);
      #1 check("R7 irq from level bit", {31'b0, irq}, 1);
      @(negedge clk); tx_thresh = 0;
      #1 check("R3 R7 level drop", {31'b0, irq}, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            t_reset(); t_levels(); t_sticky(); t_race(); t_mask(); t_irq();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_ok, n_chk);
      $finish;
   end
endmodule